// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from a single input line, using only the system clock and an enable pulse that fires sixteen times per bit period. It validates a start bit and samples every later bit near its middle. It collects 5 to 8 data bits, least significant first, and then checks an optional parity bit and one, one and a half or two stop bits. Character length, parity type and stop length are chosen at run time through three small select inputs. These selects must stay unchanged while a character is being received.

A character with no error is written into a single holding register and flagged as ready. A parity mismatch, a low stop sample, or a good character that arrives while the holding register is still unread each raise their own flag, and any raised flag drives the interrupt request. One read pulse acknowledges the holding register and clears every flag.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rx_data` is 0, and `rx_valid`, all three error flags and `irq` are low. The internal view of the line starts at the idle level 1.
- R2: A low line seen on an enable tick while idle starts a character. If the line is high again at the 8th tick after that detection, the attempt is dropped: no flag or data changes, and the block waits for a new low.
- R3: Data bits are sampled every 16 ticks after the start check, least significant bit first. `len_sel` 0, 1, 2, 3 selects 5, 6, 7, 8 bits, and bits above the character length read as 0 in `rx_data`.
- R4: `par_sel` 1 selects even parity (the parity bit equals the XOR of the data bits), 2 selects odd parity (its inverse), and 0 or 3 selects no parity bit. A mismatch sets `parity_err` and leaves `rx_data` and `rx_valid` unchanged.
- R5: `stop_sel` 0 selects one stop bit, 1 selects one and a half, and 2 or 3 selects two. Each full stop bit is sampled 16 ticks after the previous sample. The character completes on the last stop sample, or 8 ticks after the only stop sample in the one-and-a-half case.
- R6: Any sampled stop bit that is low sets `frame_err`, and that character is not stored.
- R7: A character without error that completes while `rx_valid` is set and no read is made sets `overrun_err`. In that case `rx_data` keeps the older character.
- R8: A pulse on `rd_ack` clears `rx_valid` and all three error flags at the next clock edge. A completion in the same cycle applies after the clear. `irq` is high whenever `rx_valid` or any error flag is high.
- R9: The line passes through two clock stages before it is sampled. Every result appears on the clock edge of the completing enable tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_x16 | input | 1 | One-cycle enable, 16 per bit period |
| rx_line | input | 1 | Serial input, idles high |
| len_sel | input | 2 | Character length select (5 + value bits) |
| par_sel | input | 2 | Parity select: 0/3 none, 1 even, 2 odd |
| stop_sel | input | 2 | Stop select: 0 one, 1 one and a half, 2/3 two |
| rd_ack | input | 1 | Read pulse acknowledging the holding register |
| rx_data | output | 8 | Last good character, zero-extended |
| rx_valid | output | 1 | Holding register contains an unread character |
| parity_err | output | 1 | Parity mismatch seen since the last read |
| frame_err | output | 1 | Low stop sample seen since the last read |
| overrun_err | output | 1 | Good character lost because the register was full |
| irq | output | 1 | Interrupt request, any flag or data ready |

## Verification
Every line change reaches the sampler two clock cycles later. Each decision therefore falls on an enable tick counted from the start detection: the start check at tick 8, data bit i at tick 8+16(i+1), then parity and stops in turn, and completion at the last stop sample or 8 ticks after it. Data and flags change on the clock edge of that completing tick, and a read clears them at the edge that follows the pulse. The bench model keeps its own two-stage line delay and counts ticks as plain integers from the detection. It updates its expected outputs on the same edges and compares every output at each falling clock edge. The same comparison therefore covers both the results and the exact cycle in which they appear.

// File: rtl/uart_rx_core.sv
module uart_rx_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_x16,
  input  logic       rx_line,
  input  logic [1:0] len_sel,
  input  logic [1:0] par_sel,
  input  logic [1:0] stop_sel,
  input  logic       rd_ack,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err,
  output logic       overrun_err,
  output logic       irq
);

  localparam logic [3:0] LAST_TICK = 4'd15;
  localparam logic [3:0] MID_TICK  = 4'd7;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HALF} st_t;

  st_t        st;
  logic       rx_m, rx_s;
  logic [3:0] cnt;
  logic [2:0] bit_idx;
  logic [7:0] shreg;
  logic       par_acc, perr_q, frame_bad, stop_second;
  logic       fin, fin_ferr;

  wire       par_on   = (par_sel == 2'd1) || (par_sel == 2'd2);
  wire [2:0] last_idx = {1'b1, len_sel};
  wire [7:0] aligned  = shreg >> (2'd3 - len_sel);

  assign irq = rx_valid | parity_err | frame_err | overrun_err;

  always_comb begin
    fin      = 1'b0;
    fin_ferr = frame_bad;
    if (baud_x16) begin
      if (st == S_STOP && cnt == LAST_TICK &&
          (stop_sel == 2'd0 || (stop_sel[1] && stop_second))) begin
        fin      = 1'b1;
        fin_ferr = frame_bad | ~rx_s;
      end else if (st == S_HALF && cnt == MID_TICK) begin
        fin = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      rx_m        <= 1'b1;
      rx_s        <= 1'b1;
      cnt         <= '0;
      bit_idx     <= '0;
      shreg       <= '0;
      par_acc     <= 1'b0;
      perr_q      <= 1'b0;
      frame_bad   <= 1'b0;
      stop_second <= 1'b0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      parity_err  <= 1'b0;
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      rx_m <= rx_line;
      rx_s <= rx_m;

      if (baud_x16) begin
        unique case (st)
          S_IDLE: begin
            if (!rx_s) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == MID_TICK) begin
              cnt <= '0;
              if (rx_s) st <= S_IDLE;
              else begin
                st        <= S_DATA;
                bit_idx   <= '0;
                shreg     <= '0;
                par_acc   <= 1'b0;
                perr_q    <= 1'b0;
                frame_bad <= 1'b0;
              end
            end else cnt <= cnt + 4'd1;
          end
          S_DATA: begin
            if (cnt == LAST_TICK) begin
              cnt     <= '0;
              shreg   <= {rx_s, shreg[7:1]};
              par_acc <= par_acc ^ rx_s;
              bit_idx <= bit_idx + 3'd1;
              if (bit_idx == last_idx) begin
                st          <= par_on ? S_PAR : S_STOP;
                stop_second <= 1'b0;
              end
            end else cnt <= cnt + 4'd1;
          end
          S_PAR: begin
            if (cnt == LAST_TICK) begin
              cnt    <= '0;
              perr_q <= rx_s != (par_acc ^ (par_sel == 2'd2));
              st     <= S_STOP;
            end else cnt <= cnt + 4'd1;
          end
          S_STOP: begin
            if (cnt == LAST_TICK) begin
              cnt         <= '0;
              frame_bad   <= frame_bad | ~rx_s;
              stop_second <= 1'b1;
              if (stop_sel == 2'd1) st <= S_HALF;
              else if (stop_sel == 2'd0 || stop_second) st <= S_IDLE;
            end else cnt <= cnt + 4'd1;
          end
          S_HALF: begin
            if (cnt == MID_TICK) begin
              cnt <= '0;
              st  <= S_IDLE;
            end else cnt <= cnt + 4'd1;
          end
          default: st <= S_IDLE;
        endcase
      end

      if (rd_ack) begin
        rx_valid    <= 1'b0;
        parity_err  <= 1'b0;
        frame_err   <= 1'b0;
        overrun_err <= 1'b0;
      end

      if (fin) begin
        if (perr_q)   parity_err <= 1'b1;
        if (fin_ferr) frame_err  <= 1'b1;
        if (!perr_q && !fin_ferr) begin
          if (rx_valid && !rd_ack) overrun_err <= 1'b1;
          else begin
            rx_data  <= aligned;
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_core_sva.sv
module uart_rx_core_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_x16,
  input logic       rd_ack,
  input logic       fin,
  input logic [1:0] len_sel,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       overrun_err
);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> ((rx_data >> (len_sel + 4'd5)) == 8'd0)); // R3

  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(baud_x16)); // R9

  AST_OVR_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> rx_valid); // R7

  AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rd_ack |=> rx_valid && $stable(rx_data)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !fin |=> !rx_valid && !overrun_err); // R8

endmodule

bind uart_rx_core uart_rx_core_sva u_sva (
  .clk(clk), .rst_n(rst_n), .baud_x16(baud_x16), .rd_ack(rd_ack), .fin(fin),
  .len_sel(len_sel), .rx_data(rx_data), .rx_valid(rx_valid), .overrun_err(overrun_err)
);

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;

  localparam int BT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd0;
  logic       rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, parity_err, frame_err, overrun_err, irq;

  int    n_tests = 0, n_fail = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  uart_rx_core uut (
    .clk(clk), .rst_n(rst_n), .baud_x16(tick), .rx_line(rxd),
    .len_sel(cfg_len), .par_sel(cfg_par), .stop_sel(cfg_stop), .rd_ack(rd),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
    .frame_err(frame_err), .overrun_err(overrun_err), .irq(irq)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  // reference model
  logic       d1, d2, seen;
  bit         busy;
  int         age;
  logic [7:0] m_dat;
  bit         m_perr, m_ferr, fin;
  logic [7:0] e_data;
  bit         e_valid, e_perr, e_ferr, e_ovr;

  always @(posedge clk) begin
    if (!rst_n) begin
      d1 = 1; d2 = 1; busy = 0; age = 0; m_dat = 0;
      e_data = 0; e_valid = 0; e_perr = 0; e_ferr = 0; e_ovr = 0;
    end else begin
      int len, s1, endt;
      bit pon;
      seen = d2; d2 = d1; d1 = rxd;
      fin = 0;
      if (tick) begin
        if (!busy) begin
          if (seen == 0) begin
            busy = 1; age = 0; m_dat = 0; m_perr = 0; m_ferr = 0;
          end
        end else begin
          age++;
          len = int'(cfg_len) + 5;
          pon = (cfg_par == 2'd1) || (cfg_par == 2'd2);
          s1 = 8 + 16 * (len + 1 + (pon ? 1 : 0));
          if (age == 8 && seen) busy = 0;
          for (int i = 0; i < len; i++)
            if (age == 8 + 16 * (i + 1)) m_dat[i] = seen;
          if (pon && age == 8 + 16 * (len + 1))
            m_perr = (seen != ((^m_dat) ^ (cfg_par == 2'd2)));
          if ((age == s1 || (cfg_stop >= 2 && age == s1 + 16)) && !seen) m_ferr = 1;
          endt = (cfg_stop == 0) ? s1 : (cfg_stop == 1) ? s1 + 8 : s1 + 16;
          if (busy && age == endt) begin fin = 1; busy = 0; end
        end
      end
      if (rd) begin e_valid = 0; e_perr = 0; e_ferr = 0; e_ovr = 0; end
      if (fin) begin
        if (m_perr) e_perr = 1;
        if (m_ferr) e_ferr = 1;
        if (!m_perr && !m_ferr) begin
          if (e_valid && !rd) e_ovr = 1;
          else begin e_data = m_dat; e_valid = 1; end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, {24'd0, rx_data}, {24'd0, e_data}, "rx_data");
      check(cur_req, {27'd0, rx_valid, parity_err, frame_err, overrun_err, irq},
            {27'd0, e_valid, e_perr, e_ferr, e_ovr, (e_valid | e_perr | e_ferr | e_ovr)},
            "flags{valid,par,frame,ovr,irq}");
    end
  end

  task automatic send(input logic [7:0] d, input logic [1:0] ln, input logic [1:0] pm,
                      input bit flip_par, input logic [1:0] sm, input int bad_stop);
    bit p;
    int n;
    n = int'(ln) + 5;
    cfg_len = ln; cfg_par = pm; cfg_stop = sm;
    p = 0;
    @(negedge clk);
    rxd = 0; repeat (BT) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = d[i]; p ^= d[i];
      repeat (BT) @(negedge clk);
    end
    if (pm == 2'd1 || pm == 2'd2) begin
      rxd = p ^ (pm == 2'd2) ^ flip_par;
      repeat (BT) @(negedge clk);
    end
    rxd = (bad_stop == 0) ? 1'b0 : 1'b1; repeat (BT) @(negedge clk);
    if (sm == 2'd1) begin rxd = 1; repeat (BT / 2) @(negedge clk); end
    if (sm >= 2'd2) begin rxd = (bad_stop == 1) ? 1'b0 : 1'b1; repeat (BT) @(negedge clk); end
    rxd = 1; repeat (BT) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1", {23'd0, rx_data, rx_valid}, 32'd0, "data/valid in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", {28'd0, parity_err, frame_err, overrun_err, irq}, 32'd0, "flags after reset");

    cur_req = "R3";
    send(8'hA5, 2'd3, 2'd0, 0, 2'd0, -1);
    check("R3", {24'd0, rx_data}, 32'hA5, "8-bit char");
    do_read();
    send(8'hF5, 2'd0, 2'd0, 0, 2'd0, -1);
    check("R3", {24'd0, rx_data}, 32'h15, "5-bit char, upper zero");
    do_read();
    send(8'h2B, 2'd1, 2'd0, 0, 2'd0, -1); do_read();
    send(8'h5C, 2'd2, 2'd0, 0, 2'd0, -1); do_read();

    cur_req = "R4";
    send(8'h37, 2'd3, 2'd1, 0, 2'd0, -1);
    check("R4", {31'd0, parity_err}, 32'd0, "even parity ok");
    do_read();
    send(8'h37, 2'd3, 2'd2, 0, 2'd0, -1); do_read();
    send(8'h0E, 2'd2, 2'd1, 1, 2'd0, -1);
    check("R4", {30'd0, parity_err, rx_valid}, 32'd2, "bad parity flagged, not stored");
    do_read();
    send(8'h0E, 2'd2, 2'd2, 1, 2'd0, -1); do_read();

    cur_req = "R5";
    send(8'h96, 2'd3, 2'd0, 0, 2'd1, -1); do_read();
    send(8'h69, 2'd3, 2'd1, 0, 2'd2, -1); do_read();
    send(8'h11, 2'd1, 2'd0, 0, 2'd3, -1); do_read();

    cur_req = "R6";
    send(8'h44, 2'd3, 2'd0, 0, 2'd0, 0);
    check("R6", {30'd0, frame_err, rx_valid}, 32'd2, "low stop");
    do_read();
    send(8'h44, 2'd3, 2'd0, 0, 2'd2, 1); do_read();

    cur_req = "R7";
    send(8'h3C, 2'd3, 2'd0, 0, 2'd0, -1);
    send(8'hC3, 2'd3, 2'd0, 0, 2'd0, -1);
    check("R7", {23'd0, rx_data, overrun_err}, {23'd0, 8'h3C, 1'b1}, "overrun keeps old");

    cur_req = "R8";
    do_read();
    check("R8", {31'd0, irq}, 32'd0, "read clears all");

    cur_req = "R2";
    @(negedge clk); rxd = 0; repeat (12) @(negedge clk); rxd = 1;
    repeat (3 * BT) @(negedge clk);
    check("R2", {31'd0, irq}, 32'd0, "glitch ignored");
    cur_req = "R9";
    send(8'h81, 2'd3, 2'd0, 0, 2'd0, -1); do_read();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule